// File: doc/BRIEF.md
# Two-Phase Instruction Decoder with Program Counter Control

This block sits in the control path of a small 6-bit processor whose instruction words are 12 bits wide. Each instruction takes two clock cycles. The first is an EXECUTE phase, in which operands and the immediate reach the ALU. The second is a STORE phase, in which the result, the flags and the program counter are written. The block alternates between the two phases. From the instruction word held at its input, it produces the register-file select and enable for the current phase, the ALU opcode, the jump condition code, the immediate-on-bus enable, the port strobes and the flag-write strobe.

The block contains a jump condition evaluator that combines the condition field with the carry, overflow, negative and zero flags. It also holds the 12-bit program counter as a high and a low 6-bit half. In STORE the counter either increments or takes a jump target. A short jump replaces only the low half. A far jump also loads the high half from register E.

The top-level bits [11:10] select the instruction format: 00 is an ALU operation register-to-register, 01 is a short jump and 10 is a far jump. When the top bits are 11, bit 9 selects copy-immediate (0) or ALU-with-immediate (1). A set halt flag freezes the phase sequence in EXECUTE.

Top module: `twophase_decoder`

## Requirements
- R1: While rst_n is low, the phase output shows EXECUTE (phase_exec_o=1), pc_o is 0 and all three PC controls are low.
- R2: With halt_i low, the phase alternates EXECUTE, STORE, EXECUTE on every clock, starting in EXECUTE after reset.
- R3: When halt_i is high in an EXECUTE cycle, the next cycle is again EXECUTE. While halted, no PC control is raised and pc_o holds its value.
- R4: Register codes are PORT=000, ACCU=001, B=010, A=011, E=100, FLAGS=101, D=110 and C=111. Format 00 (op [9:6], dest [5:3], src [2:0]) selects src in EXECUTE and dest in STORE, with the enable high in both phases. Format 110 (dest [8:6]) and format 111 (dest ACCU) enable only in STORE. Jumps never enable. Whenever the enable is low, the select reads 100.
- R5: The ALU opcode is bits [9:6] for format 00, {0, bits[8:6]} for format 111, and 1000 (pass operand B) for copy-immediate and for both jump formats.
- R6: cond_o always equals bits [9:6]. cond_taken_o follows these codes, with flag bits C=0, O=1, N=2, Z=3: 0000 always; 0001 Z; 0010 !Z; 0011 O&!Z; 0100 O|Z; 0101 !O&!Z; 0110 !O|Z; 0111 C; 1000 !C; 1001 !N&!Z; 1010 !N|Z; 1011 N&!Z; 1100 N|Z; 1101 to 1111 never.
- R7: imm_bus_en_o is high in EXECUTE for every format except format 00 and low in STORE. imm_o always equals bits [5:0].
- R8: port_rd_o is high in both phases when format 00 has src PORT. port_wr_o is high in both phases when format 00 or format 110 has dest PORT. Both can be high together.
- R9: flags_wr_o is high only in STORE, for format 111 and for format 00 whose dest is not FLAGS.
- R10: PC controls are low in EXECUTE. In STORE, a taken jump raises pcl_load_o, plus pch_load_o for a far jump. Any other instruction raises pc_inc_o instead.
- R11: pc_inc_o advances pc_o by one across both halves, wrapping from 4095 to 0. pcl_load_o loads the low half with bits [5:0], and pch_load_o loads the high half from reg_e_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 12 | Current instruction word, held for both phases |
| cflags_i | input | 4 | Flags {Z,N,O,C} from the flag register |
| halt_i | input | 1 | Halt flag from the flag register |
| reg_e_i | input | 6 | Contents of register E |
| phase_exec_o | output | 1 | High in EXECUTE, low in STORE |
| reg_sel_o | output | 3 | Register-file select |
| reg_en_o | output | 1 | Register-file enable |
| alu_op_o | output | 4 | ALU opcode |
| cond_o | output | 4 | Jump condition code |
| cond_taken_o | output | 1 | Condition evaluator result |
| imm_bus_en_o | output | 1 | Immediate drives the data bus |
| imm_o | output | 6 | Immediate field |
| port_rd_o | output | 1 | Port read strobe |
| port_wr_o | output | 1 | Port write strobe |
| flags_wr_o | output | 1 | Load ALU flags into the flag register |
| pcl_load_o | output | 1 | Load PC low half with the immediate |
| pch_load_o | output | 1 | Load PC high half from register E |
| pc_inc_o | output | 1 | Increment PC |
| pc_o | output | 12 | Program counter |

## Verification
The port read and port write strobes can both be high for one instruction. This is provoked with a register-to-register ALU word whose source and destination are both PORT. Both strobes are then expected high through EXECUTE and STORE, while the select moves from source to destination. A related case writes FLAGS as the destination, where the register write and the suppressed flag write fall in the same STORE cycle. A far jump to 63 with E=63, followed by an increment, checks the carry from the low half into the high half and the wrap to zero. Every cycle is compared against a queue of predicted outputs.

// File: rtl/dec_pkg.sv
package dec_pkg;

  typedef enum logic {
    PH_EXEC  = 1'b0,
    PH_STORE = 1'b1
  } phase_e;

  typedef enum logic [2:0] {
    FMT_ALU_REG,
    FMT_SHORT,
    FMT_FAR,
    FMT_COPY,
    FMT_ALU_IMM
  } fmt_e;

  localparam logic [2:0] RC_PORT  = 3'b000;
  localparam logic [2:0] RC_ACCU  = 3'b001;
  localparam logic [2:0] RC_FLAGS = 3'b101;
  localparam logic [2:0] RC_IDLE  = 3'b100;
  localparam logic [3:0] OP_PASSB = 4'b1000;

endpackage

// File: rtl/dec_phase_seq.sv
module dec_phase_seq
  import dec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   halt_i,
  output phase_e phase_o
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_EXEC:  if (!halt_i) phase_d = PH_STORE;
      PH_STORE: phase_d = PH_EXEC;
      default:  phase_d = PH_EXEC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_EXEC;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/dec_cond_eval.sv
module dec_cond_eval #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cond_i,
  input  logic [3:0]    flags_i,   // {Z,N,O,C}
  output logic          taken_o
);

  logic fc, fo, fn, fz;

  always_comb begin
    fc = flags_i[0];
    fo = flags_i[1];
    fn = flags_i[2];
    fz = flags_i[3];
    case (cond_i)
      4'd0:    taken_o = 1'b1;
      4'd1:    taken_o = fz;
      4'd2:    taken_o = !fz;
      4'd3:    taken_o = fo && !fz;
      4'd4:    taken_o = fo || fz;
      4'd5:    taken_o = !fo && !fz;
      4'd6:    taken_o = !fo || fz;
      4'd7:    taken_o = fc;
      4'd8:    taken_o = !fc;
      4'd9:    taken_o = !fn && !fz;
      4'd10:   taken_o = !fn || fz;
      4'd11:   taken_o = fn && !fz;
      4'd12:   taken_o = fn || fz;
      default: taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dec_field_decode.sv
module dec_field_decode
  import dec_pkg::*;
#(
  parameter int DW  = 6,
  parameter int RW  = 3,
  parameter int OPW = 4,
  parameter int IW  = 2 * DW
) (
  input  logic [IW-1:0]  instr_i,
  input  phase_e         phase_i,
  input  logic           taken_i,
  output logic [RW-1:0]  reg_sel_o,
  output logic           reg_en_o,
  output logic [OPW-1:0] alu_op_o,
  output logic           imm_bus_en_o,
  output logic           port_rd_o,
  output logic           port_wr_o,
  output logic           flags_wr_o,
  output logic           pcl_load_o,
  output logic           pch_load_o,
  output logic           pc_inc_o
);

  localparam int OP_LO = DW;
  localparam int OP_HI = DW + OPW - 1;
  localparam int DH_HI = DW + RW - 1;

  fmt_e          fmt;
  logic          store;
  logic          is_jump;
  logic [RW-1:0] src_f;
  logic [RW-1:0] dst_lo_f;
  logic [RW-1:0] dst_hi_f;

  always_comb begin
    case (instr_i[IW-1:IW-2])
      2'b00:   fmt = FMT_ALU_REG;
      2'b01:   fmt = FMT_SHORT;
      2'b10:   fmt = FMT_FAR;
      default: fmt = instr_i[IW-3] ? FMT_ALU_IMM : FMT_COPY;
    endcase
  end

  assign store    = (phase_i == PH_STORE);
  assign is_jump  = (fmt == FMT_SHORT) || (fmt == FMT_FAR);
  assign src_f    = instr_i[RW-1:0];
  assign dst_lo_f = instr_i[2*RW-1:RW];
  assign dst_hi_f = instr_i[DH_HI:DW];

  always_comb begin
    reg_sel_o    = RC_IDLE;
    reg_en_o     = 1'b0;
    alu_op_o     = OP_PASSB;
    imm_bus_en_o = 1'b0;
    port_rd_o    = 1'b0;
    port_wr_o    = 1'b0;
    flags_wr_o   = 1'b0;
    pcl_load_o   = 1'b0;
    pch_load_o   = 1'b0;
    pc_inc_o     = 1'b0;
    case (fmt)
      FMT_ALU_REG: begin
        alu_op_o   = instr_i[OP_HI:OP_LO];
        reg_en_o   = 1'b1;
        reg_sel_o  = store ? dst_lo_f : src_f;
        port_rd_o  = (src_f == RC_PORT);
        port_wr_o  = (dst_lo_f == RC_PORT);
        flags_wr_o = store && (dst_lo_f != RC_FLAGS);
      end
      FMT_COPY: begin
        imm_bus_en_o = !store;
        port_wr_o    = (dst_hi_f == RC_PORT);
        if (store) begin
          reg_sel_o = dst_hi_f;
          reg_en_o  = 1'b1;
        end
      end
      FMT_ALU_IMM: begin
        alu_op_o     = {1'b0, instr_i[DH_HI:DW]};
        imm_bus_en_o = !store;
        if (store) begin
          reg_sel_o  = RC_ACCU;
          reg_en_o   = 1'b1;
          flags_wr_o = 1'b1;
        end
      end
      default: begin
        imm_bus_en_o = !store;
      end
    endcase
    if (store) begin
      if (is_jump && taken_i) begin
        pcl_load_o = 1'b1;
        pch_load_o = (fmt == FMT_FAR);
      end else begin
        pc_inc_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dec_pc_reg.sv
module dec_pc_reg #(
  parameter int DW = 6,
  parameter int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_lo_i,
  input  logic          load_hi_i,
  input  logic          inc_i,
  input  logic [DW-1:0] lo_val_i,
  input  logic [DW-1:0] hi_val_i,
  output logic [PW-1:0] pc_o
);

  logic [DW-1:0] lo_q, hi_q, lo_d, hi_d;
  logic          pc_en;
  logic [PW-1:0] pc_plus;

  assign pc_plus = {hi_q, lo_q} + PW'(1);
  assign pc_en   = load_lo_i || inc_i;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (load_lo_i) begin
      lo_d = lo_val_i;
      if (load_hi_i) hi_d = hi_val_i;
    end else if (inc_i) begin
      {hi_d, lo_d} = pc_plus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (pc_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign pc_o = {hi_q, lo_q};

endmodule

// File: rtl/twophase_decoder.sv
module twophase_decoder
  import dec_pkg::*;
#(
  parameter int DW  = 6,
  parameter int RW  = 3,
  parameter int OPW = 4,
  parameter int CW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*DW-1:0]   instr_i,
  input  logic [3:0]        cflags_i,
  input  logic              halt_i,
  input  logic [DW-1:0]     reg_e_i,
  output logic              phase_exec_o,
  output logic [RW-1:0]     reg_sel_o,
  output logic              reg_en_o,
  output logic [OPW-1:0]    alu_op_o,
  output logic [CW-1:0]     cond_o,
  output logic              cond_taken_o,
  output logic              imm_bus_en_o,
  output logic [DW-1:0]     imm_o,
  output logic              port_rd_o,
  output logic              port_wr_o,
  output logic              flags_wr_o,
  output logic              pcl_load_o,
  output logic              pch_load_o,
  output logic              pc_inc_o,
  output logic [2*DW-1:0]   pc_o
);

  localparam int IW = 2 * DW;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  phase_e     phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dec_phase_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .halt_i (halt_i),
    .phase_o(phase)
  );

  assign cond_o = instr_i[DW+CW-1:DW];

  dec_cond_eval #(.CW(CW)) u_cond (
    .cond_i (cond_o),
    .flags_i(cflags_i),
    .taken_o(cond_taken_o)
  );

  dec_field_decode #(.DW(DW), .RW(RW), .OPW(OPW), .IW(IW)) u_dec (
    .instr_i     (instr_i),
    .phase_i     (phase),
    .taken_i     (cond_taken_o),
    .reg_sel_o   (reg_sel_o),
    .reg_en_o    (reg_en_o),
    .alu_op_o    (alu_op_o),
    .imm_bus_en_o(imm_bus_en_o),
    .port_rd_o   (port_rd_o),
    .port_wr_o   (port_wr_o),
    .flags_wr_o  (flags_wr_o),
    .pcl_load_o  (pcl_load_o),
    .pch_load_o  (pch_load_o),
    .pc_inc_o    (pc_inc_o)
  );

  assign imm_o = instr_i[DW-1:0];

  dec_pc_reg #(.DW(DW)) u_pc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_lo_i(pcl_load_o),
    .load_hi_i(pch_load_o),
    .inc_i    (pc_inc_o),
    .lo_val_i (imm_o),
    .hi_val_i (reg_e_i),
    .pc_o     (pc_o)
  );

  assign phase_exec_o = (phase == PH_EXEC);

endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt_i,
  input logic          phase_exec_o,
  input logic          imm_bus_en_o,
  input logic          flags_wr_o,
  input logic          pcl_load_o,
  input logic          pch_load_o,
  input logic          pc_inc_o,
  input logic [PW-1:0] pc_o
);

  // R2
  run_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_exec_o && !halt_i) |=> !phase_exec_o);

  // R2
  store_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_exec_o |=> phase_exec_o);

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_exec_o && halt_i) |=> (phase_exec_o && $stable(pc_o)));

  // R10
  exec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_exec_o |-> !(pcl_load_o || pch_load_o || pc_inc_o));

  // R10
  store_one_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_exec_o |-> ($countones({pcl_load_o, pc_inc_o}) == 1));

  // R10
  high_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pch_load_o |-> pcl_load_o);

  // R7
  imm_exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_bus_en_o |-> phase_exec_o);

  // R9
  flags_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_wr_o |-> !phase_exec_o);

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc_o |=> (pc_o == $past(pc_o) + PW'(1)));

endmodule

bind twophase_decoder dec_checker #(.PW(2*DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .halt_i      (halt_i),
  .phase_exec_o(phase_exec_o),
  .imm_bus_en_o(imm_bus_en_o),
  .flags_wr_o  (flags_wr_o),
  .pcl_load_o  (pcl_load_o),
  .pch_load_o  (pch_load_o),
  .pc_inc_o    (pc_inc_o),
  .pc_o        (pc_o)
);

// File: tb/twophase_decoder_tb_top.sv
module twophase_decoder_tb_top;

  typedef struct {
    logic        ph_exec;
    logic [2:0]  sel;
    logic        en;
    logic [3:0]  alu;
    logic [3:0]  cond;
    logic        taken;
    logic        imm_en;
    logic [5:0]  imm;
    logic        prd;
    logic        pwr;
    logic        fwr;
    logic        pcl;
    logic        pch;
    logic        inc;
    logic [11:0] pc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] instr;
  logic [3:0]  cflags;
  logic        halt;
  logic [5:0]  reg_e;
  logic        phase_exec_o, reg_en_o, cond_taken_o, imm_bus_en_o;
  logic        port_rd_o, port_wr_o, flags_wr_o, pcl_load_o, pch_load_o, pc_inc_o;
  logic [2:0]  reg_sel_o;
  logic [3:0]  alu_op_o, cond_o;
  logic [5:0]  imm_o;
  logic [11:0] pc_o;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];
  logic [11:0] model_pc;
  bit   done = 0;

  always #10 clk = ~clk;

  twophase_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .cflags_i(cflags),
    .halt_i(halt), .reg_e_i(reg_e), .phase_exec_o(phase_exec_o),
    .reg_sel_o(reg_sel_o), .reg_en_o(reg_en_o), .alu_op_o(alu_op_o),
    .cond_o(cond_o), .cond_taken_o(cond_taken_o), .imm_bus_en_o(imm_bus_en_o),
    .imm_o(imm_o), .port_rd_o(port_rd_o), .port_wr_o(port_wr_o),
    .flags_wr_o(flags_wr_o), .pcl_load_o(pcl_load_o), .pch_load_o(pch_load_o),
    .pc_inc_o(pc_inc_o), .pc_o(pc_o)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // R6 condition table, flags {Z,N,O,C}
  function automatic logic cond_model(input logic [3:0] c, input logic [3:0] f);
    logic C, O, N, Z;
    C = f[0]; O = f[1]; N = f[2]; Z = f[3];
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return Z;
      4'd2:  return !Z;
      4'd3:  return O & !Z;
      4'd4:  return O | Z;
      4'd5:  return !O & !Z;
      4'd6:  return !O | Z;
      4'd7:  return C;
      4'd8:  return !C;
      4'd9:  return !N & !Z;
      4'd10: return !N | Z;
      4'd11: return N & !Z;
      4'd12: return N | Z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic exp_t predict(input logic [11:0] w, input logic [3:0] f, input logic st);
    exp_t e;
    logic jump, far;
    e.ph_exec = !st;
    e.sel = 3'b100; e.en = 0; e.alu = 4'b1000; e.imm_en = 0;
    e.prd = 0; e.pwr = 0; e.fwr = 0; e.pcl = 0; e.pch = 0; e.inc = 0;
    e.cond = w[9:6]; e.imm = w[5:0]; e.taken = cond_model(w[9:6], f);
    e.pc = model_pc;
    jump = (w[11:10] == 2'b01) || (w[11:10] == 2'b10);
    far  = (w[11:10] == 2'b10);
    if (w[11:10] == 2'b00) begin
      e.alu = w[9:6]; e.en = 1; e.sel = st ? w[5:3] : w[2:0];
      e.prd = (w[2:0] == 3'b000); e.pwr = (w[5:3] == 3'b000);
      e.fwr = st && (w[5:3] != 3'b101);
    end else if (w[11:9] == 3'b110) begin
      e.imm_en = !st; e.pwr = (w[8:6] == 3'b000);
      if (st) begin e.en = 1; e.sel = w[8:6]; end
    end else if (w[11:9] == 3'b111) begin
      e.alu = {1'b0, w[8:6]}; e.imm_en = !st;
      if (st) begin e.en = 1; e.sel = 3'b001; e.fwr = 1; end
    end else begin
      e.imm_en = !st;
    end
    if (st) begin
      if (jump && e.taken) begin e.pcl = 1; e.pch = far; end
      else e.inc = 1;
    end
    return e;
  endfunction

  // called at a negedge in EXECUTE; returns at the next EXECUTE negedge
  task automatic run_instr(input logic [11:0] w, input logic [3:0] f, input logic [5:0] e);
    exp_t x;
    instr = w; cflags = f; reg_e = e; halt = 0;
    q.push_back(predict(w, f, 1'b0));
    @(negedge clk);
    x = predict(w, f, 1'b1);
    q.push_back(x);
    if (x.pcl) begin
      model_pc[5:0] = w[5:0];
      if (x.pch) model_pc[11:6] = e;
    end else begin
      model_pc = model_pc + 12'd1;
    end
    @(negedge clk);
  endtask

  task automatic run_halted(input logic [11:0] w, input int n);
    instr = w; cflags = 4'b0000; halt = 1;
    for (int i = 0; i < n; i++) begin
      q.push_back(predict(w, 4'b0000, 1'b0));
      @(negedge clk);
    end
    halt = 0;
  endtask

  // monitor: compare one queued item per cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R2",  {11'd0, phase_exec_o}, {11'd0, e.ph_exec});
        chk("R4",  {8'd0, reg_en_o, reg_sel_o}, {8'd0, e.en, e.sel});
        chk("R5",  {8'd0, alu_op_o}, {8'd0, e.alu});
        chk("R6",  {7'd0, cond_taken_o, cond_o}, {7'd0, e.taken, e.cond});
        chk("R7",  {5'd0, imm_bus_en_o, imm_o}, {5'd0, e.imm_en, e.imm});
        chk("R8",  {10'd0, port_rd_o, port_wr_o}, {10'd0, e.prd, e.pwr});
        chk("R9",  {11'd0, flags_wr_o}, {11'd0, e.fwr});
        chk("R10", {9'd0, pcl_load_o, pch_load_o, pc_inc_o}, {9'd0, e.pcl, e.pch, e.inc});
        chk("R11", pc_o, e.pc);
      end
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; instr = 12'h000; cflags = 4'h0; halt = 0; reg_e = 6'h00;
    model_pc = 12'h000;
    repeat (2) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", {11'd0, phase_exec_o}, 12'd1);
    chk("R1", pc_o, 12'h000);
    chk("R1", {9'd0, pcl_load_o, pch_load_o, pc_inc_o}, 12'd0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 R5 R7: copy immediate to A
    run_instr({3'b110, 3'b011, 6'h2A}, 4'h0, 6'h00);
    // R4 R5 R9: register ALU op, dest C src B
    run_instr({2'b00, 4'b0010, 3'b111, 3'b010}, 4'h0, 6'h00);
    // R8: port both source and destination
    run_instr({2'b00, 4'b0000, 3'b000, 3'b000}, 4'h0, 6'h00);
    // R9: FLAGS destination suppresses flag write
    run_instr({2'b00, 4'b0001, 3'b101, 3'b001}, 4'h0, 6'h00);
    // R8: copy immediate to PORT
    run_instr({3'b110, 3'b000, 6'h15}, 4'h0, 6'h00);
    // R5 R9: ALU with immediate, compare
    run_instr({3'b111, 3'b110, 6'h07}, 4'h0, 6'h00);
    // R6 R10: every condition code, several flag patterns, short jumps
    for (int f = 0; f < 16; f += 5) begin
      for (int c = 0; c < 16; c++) begin
        run_instr({2'b01, 4'(c), 6'(c * 3)}, 4'(f), 6'h3F);
      end
    end
    // R10 R11: taken far jump loads both halves
    run_instr({2'b10, 4'b0000, 6'h3F}, 4'h0, 6'h15);
    run_instr({3'b110, 3'b001, 6'h01}, 4'h0, 6'h00);
    // R11: wrap from 4095 to 0
    run_instr({2'b10, 4'b0000, 6'h3F}, 4'h0, 6'h3F);
    run_instr({3'b110, 3'b010, 6'h02}, 4'h0, 6'h00);
    // R10: untaken far jump increments
    run_instr({2'b10, 4'b1101, 6'h10}, 4'hF, 6'h2A);
    // R3: halt holds EXECUTE and the PC
    run_halted({2'b00, 4'b0000, 3'b001, 3'b011}, 5);
    run_instr({2'b00, 4'b0000, 3'b001, 3'b011}, 4'h0, 6'h00);
    run_instr({2'b01, 4'b0000, 6'h05}, 4'h0, 6'h00);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule